// File: doc/BRIEF.md
# CAN Controller Mode Handshake and Configuration Guard

This block governs how a CAN controller moves between running, initialization and sleep. Software sets or clears a request bit for each mode through a control write. The controller answers with an acknowledge flag, and it changes that flag only at a point where the bus is idle, so a frame in progress is never cut off. A mode is in force only while its request bit and its acknowledge flag are both 1.

The block also holds the configuration registers. The first one is an 8-bit bus-timing register. It carries a 2-bit resynchronization jump width code in bits 7:6 and a 6-bit baud rate prescaler in bits 5:0. A set of acceptance-filter registers follows it. Any register can be read at any time, but writes are accepted only while initialization mode is in force. A rejected write leaves the register untouched and raises a sticky error flag.

While sleep is in force, bus activity can wake the controller, but only if wake-up was enabled by software. The jump width is exported to the bit-timing logic already converted to time quanta.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset, both request bits, both acknowledge flags, the wake enable, the error flag and every configuration register are 0. The jump width output reads 1 and the prescaler output reads 0.
- R2: A control write (ctl_we=1) loads init_req, sleep_req and wake_en from their data inputs. The new values are visible one cycle later. There is no write path to the acknowledge flags.
- R3: An acknowledge flag rises one cycle after a cycle in which its request was 1, bus_idle was 1 and no control write occurred. It never changes at the edge that takes a control write.
- R4: After a request bit is cleared, its acknowledge flag falls one cycle after the next cycle with bus_idle=1 and no control write. While bus_idle is 0 the flag holds.
- R5: init_active equals init_req AND init_ack, and sleep_active equals sleep_req AND sleep_ack. A configuration write is stored only while init_active is 1.
- R6: A configuration write made while init_active is 0, or made to an address at or above NUM_FILT+1, changes no register and sets cfg_wr_err. Only reset clears cfg_wr_err.
- R7: With wake_en=1, bus_activity=1 while sleep_ack is 1 clears both sleep_ack and sleep_req at the next edge, and this takes priority over a control write.
- R8: With wake_en=0, bus_activity has no effect on sleep_ack or sleep_req.
- R9: Address 0 holds the bus-timing register. Its bits 7:6 are the jump width code c, and sjw_tq outputs c+1. Its bits 5:0 appear on brp.
- R10: Addresses 1 to NUM_FILT are filter registers that read back exactly what was written. Reads are combinational at any time, and out-of-range reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_init | input | 1 | Initialization request value to write |
| ctl_sleep | input | 1 | Sleep request value to write |
| ctl_wake | input | 1 | Wake-up enable value to write |
| bus_idle | input | 1 | Bus is at a safe point for a mode change |
| bus_activity | input | 1 | Activity seen on the bus |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_waddr | input | ADDR_W (5) | Configuration write address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_raddr | input | ADDR_W (5) | Configuration read address |
| cfg_rdata | output | 8 | Configuration read data |
| init_req | output | 1 | Initialization request bit |
| init_ack | output | 1 | Initialization acknowledge flag |
| sleep_req | output | 1 | Sleep request bit |
| sleep_ack | output | 1 | Sleep acknowledge flag |
| wake_en | output | 1 | Wake-up enable bit |
| init_active | output | 1 | Initialization mode in force |
| sleep_active | output | 1 | Sleep mode in force |
| cfg_wr_err | output | 1 | Sticky rejected-write flag |
| sjw_tq | output | 3 | Jump width in time quanta (1 to 4) |
| brp | output | 6 | Baud rate prescaler field |

## Verification
The assertions assume that reset is held for several cycles, so that no register is unknown when the checks start. They also assume bus_idle and bus_activity are clean levels sampled at the clock. The acknowledge checks further assume that a control write is a single-cycle strobe, whose effect the next edge already shows.

The stimulus drives every input on the falling edge, holds reset for four cycles and pulses each strobe for exactly one cycle. It never asserts bus_activity in a way that would make a wake-up depend on a value the bench has not set.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    localparam int DEF_NUM_FILT = 16;
    localparam int DATA_W       = 8;

    typedef struct packed {
        logic [1:0] sjw_code;
        logic [5:0] prescale;
    } bus_timing_t;

    typedef enum logic [1:0] {
        HS_RUN      = 2'b00,
        HS_LEAVING  = 2'b01,
        HS_ENTERING = 2'b10,
        HS_ACTIVE   = 2'b11
    } hs_state_e;

    function automatic hs_state_e hs_decode(input logic req, input logic ack);
        return hs_state_e'({req, ack});
    endfunction

    function automatic logic [2:0] sjw_to_tq(input logic [1:0] code);
        return {1'b0, code} + 3'd1;
    endfunction

endpackage

// File: rtl/can_mode_hs.sv
module can_mode_hs
    import can_mode_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_we,
    input  logic req_wval,
    input  logic bus_idle,
    input  logic wake_evt,
    output logic req,
    output logic ack
);

    hs_state_e state;

    assign state = hs_decode(req, ack);

    always_ff @(posedge clk) begin
        if (rst) begin
            req <= 1'b0;
            ack <= 1'b0;
        end else if (wake_evt) begin
            req <= 1'b0;
            ack <= 1'b0;
        end else if (req_we) begin
            req <= req_wval;
        end else if (bus_idle) begin
            case (state)
                HS_ENTERING: ack <= 1'b1;
                HS_LEAVING:  ack <= 1'b0;
                default:     ack <= ack;
            endcase
        end
    end

    // R3
    ack_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> $past(req) && $past(bus_idle) && !$past(req_we));

    // R4
    ack_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ack) |-> (!$past(req) && $past(bus_idle) && !$past(req_we)) || $past(wake_evt));

    // R3
    ack_hold_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(req_we) && !$past(wake_evt)) |-> $stable(ack));

endmodule

// File: rtl/can_cfg_regs.sv
module can_cfg_regs
    import can_mode_pkg::*;
#(
    parameter int NUM_REGS = DEF_NUM_FILT + 1,
    parameter int ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   waddr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                allow,
    input  logic [ADDR_W-1:0]   raddr,
    output logic [DATA_W-1:0]   rdata,
    output bus_timing_t         timing,
    output logic                wr_err
);

    logic [DATA_W-1:0] regs [NUM_REGS];
    logic              waddr_ok;
    logic              raddr_ok;
    logic              wr_take;

    assign waddr_ok = int'(waddr) < NUM_REGS;
    assign raddr_ok = int'(raddr) < NUM_REGS;
    assign wr_take  = wr_en && allow && waddr_ok;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (wr_take && waddr == ADDR_W'(g))
                regs[g] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            wr_err <= 1'b0;
        else if (wr_en && !wr_take)
            wr_err <= 1'b1;
    end

    always_comb begin
        rdata = '0;
        if (raddr_ok)
            rdata = regs[raddr];
    end

    assign timing = bus_timing_t'(regs[0]);

    // R5
    timing_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(regs[0]) |-> $past(wr_en) && $past(allow) && ($past(waddr) == '0));

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(wr_err) |-> wr_err);

    // R6
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_err) |-> $past(wr_en) && !($past(allow) && $past(waddr_ok)));

endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
    import can_mode_pkg::*;
#(
    parameter int NUM_FILT = DEF_NUM_FILT,
    parameter int ADDR_W   = $clog2(NUM_FILT + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ctl_we,
    input  logic                ctl_init,
    input  logic                ctl_sleep,
    input  logic                ctl_wake,
    input  logic                bus_idle,
    input  logic                bus_activity,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_waddr,
    input  logic [7:0]          cfg_wdata,
    input  logic [ADDR_W-1:0]   cfg_raddr,
    output logic [7:0]          cfg_rdata,
    output logic                init_req,
    output logic                init_ack,
    output logic                sleep_req,
    output logic                sleep_ack,
    output logic                wake_en,
    output logic                init_active,
    output logic                sleep_active,
    output logic                cfg_wr_err,
    output logic [2:0]          sjw_tq,
    output logic [5:0]          brp
);

    localparam int NUM_REGS = NUM_FILT + 1;

    bus_timing_t timing;
    logic        wake_evt;

    always_ff @(posedge clk) begin
        if (rst)
            wake_en <= 1'b0;
        else if (ctl_we)
            wake_en <= ctl_wake;
    end

    assign wake_evt = wake_en && bus_activity && sleep_ack;

    can_mode_hs u_init_hs (
        .clk      (clk),
        .rst      (rst),
        .req_we   (ctl_we),
        .req_wval (ctl_init),
        .bus_idle (bus_idle),
        .wake_evt (1'b0),
        .req      (init_req),
        .ack      (init_ack)
    );

    can_mode_hs u_sleep_hs (
        .clk      (clk),
        .rst      (rst),
        .req_we   (ctl_we),
        .req_wval (ctl_sleep),
        .bus_idle (bus_idle),
        .wake_evt (wake_evt),
        .req      (sleep_req),
        .ack      (sleep_ack)
    );

    assign init_active  = init_req && init_ack;
    assign sleep_active = sleep_req && sleep_ack;

    can_cfg_regs #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W)
    ) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_we),
        .waddr  (cfg_waddr),
        .wdata  (cfg_wdata),
        .allow  (init_active),
        .raddr  (cfg_raddr),
        .rdata  (cfg_rdata),
        .timing (timing),
        .wr_err (cfg_wr_err)
    );

    assign sjw_tq = sjw_to_tq(timing.sjw_code);
    assign brp    = timing.prescale;

    // R7
    wake_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(sleep_ack && wake_en && bus_activity) |-> !sleep_ack && !sleep_req);

    // R8
    no_wake_chk: assert property (@(posedge clk) disable iff (rst)
        $past(sleep_req && sleep_ack && !wake_en && !ctl_we) |-> sleep_ack && sleep_req);

    // R9
    sjw_range_chk: assert property (@(posedge clk) disable iff (rst)
        (sjw_tq >= 3'd1) && (sjw_tq <= 3'd4));

endmodule

// File: tb/can_mode_ctrl_tb.sv
module can_mode_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NF = 16;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctl_we = 1'b0, ctl_init = 1'b0, ctl_sleep = 1'b0, ctl_wake = 1'b0;
    logic bus_idle = 1'b0, bus_activity = 1'b0;
    logic cfg_we = 1'b0;
    logic [AW-1:0] cfg_waddr = '0, cfg_raddr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic init_req, init_ack, sleep_req, sleep_ack, wake_en;
    logic init_active, sleep_active, cfg_wr_err;
    logic [2:0] sjw_tq;
    logic [5:0] brp;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_mode_ctrl #(.NUM_FILT(NF)) u_dut (
        .clk(clk), .rst(rst),
        .ctl_we(ctl_we), .ctl_init(ctl_init), .ctl_sleep(ctl_sleep), .ctl_wake(ctl_wake),
        .bus_idle(bus_idle), .bus_activity(bus_activity),
        .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
        .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .init_req(init_req), .init_ack(init_ack),
        .sleep_req(sleep_req), .sleep_ack(sleep_ack), .wake_en(wake_en),
        .init_active(init_active), .sleep_active(sleep_active),
        .cfg_wr_err(cfg_wr_err), .sjw_tq(sjw_tq), .brp(brp)
    );

    typedef struct packed {
        logic cw, ci, cs, ck, idle, act, fw;
        logic [4:0] addr;
        logic [7:0] data;
        logic e_iack, e_sack, e_sreq, e_err;
    } vec_t;

    function automatic vec_t mk(input logic cw, ci, cs, ck, idle, act, fw,
                                input logic [4:0] a, input logic [7:0] d,
                                input logic ei, es, esr, ee);
        return {cw, ci, cs, ck, idle, act, fw, a, d, ei, es, esr, ee};
    endfunction

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        mk(1,1,0,0, 0,0, 0, 5'd0, 8'h00, 0,0,0,0), // R2 init request written
        mk(0,0,0,0, 0,0, 0, 5'd0, 8'h00, 0,0,0,0), // R3 no idle, no ack
        mk(0,0,0,0, 1,0, 0, 5'd0, 8'h00, 1,0,0,0), // R3 idle -> ack
        mk(0,0,0,0, 0,0, 1, 5'd0, 8'hC5, 1,0,0,0), // R5 timing write accepted
        mk(0,0,0,0, 0,0, 1, 5'd3, 8'h5A, 1,0,0,0), // R10 filter write accepted
        mk(1,0,0,0, 1,0, 0, 5'd0, 8'h00, 1,0,0,0), // R3 ack held on write edge
        mk(0,0,0,0, 0,0, 0, 5'd0, 8'h00, 1,0,0,0), // R4 holds while busy
        mk(0,0,0,0, 1,0, 0, 5'd0, 8'h00, 0,0,0,0), // R4 drops on idle
        mk(0,0,0,0, 0,0, 1, 5'd0, 8'h11, 0,0,0,1), // R6 rejected write
        mk(1,0,1,1, 1,0, 0, 5'd0, 8'h00, 0,0,1,1), // R2 sleep + wake enable
        mk(0,0,0,0, 1,0, 0, 5'd0, 8'h00, 0,1,1,1), // R3 sleep ack
        mk(0,0,0,0, 0,1, 0, 5'd0, 8'h00, 0,0,0,1), // R7 wake clears
        mk(1,0,1,0, 1,0, 0, 5'd0, 8'h00, 0,0,1,1), // R2 sleep, wake disabled
        mk(0,0,0,0, 1,0, 0, 5'd0, 8'h00, 0,1,1,1), // R3 sleep ack
        mk(0,0,0,0, 0,1, 0, 5'd0, 8'h00, 0,1,1,1), // R8 activity ignored
        mk(1,0,0,0, 0,0, 0, 5'd0, 8'h00, 0,1,0,1), // R4 request cleared
        mk(0,0,0,0, 1,0, 0, 5'd0, 8'h00, 0,0,0,1)  // R4 sleep ack drops
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        ctl_we = 1'b0; ctl_init = 1'b0; ctl_sleep = 1'b0; ctl_wake = 1'b0;
        bus_idle = 1'b0; bus_activity = 1'b0;
        cfg_we = 1'b0; cfg_waddr = '0; cfg_wdata = '0;
    endtask

    task automatic enter_init();
        quiet(); ctl_we = 1'b1; ctl_init = 1'b1; tick();
        quiet(); bus_idle = 1'b1; tick();
        quiet();
    endtask

    task automatic cfg_write(input logic [AW-1:0] a, input logic [7:0] d);
        quiet(); cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d; tick();
        quiet();
    endtask

    task automatic do_reset();
        quiet(); rst = 1'b1;
        repeat (4) tick();
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1 reset state
        cfg_raddr = '0;
        chk("R1 init_req", init_req, 0);
        chk("R1 init_ack", init_ack, 0);
        chk("R1 sleep_ack", sleep_ack, 0);
        chk("R1 wake_en", wake_en, 0);
        chk("R1 wr_err", cfg_wr_err, 0);
        chk("R1 sjw_tq", sjw_tq, 1);
        chk("R1 brp", brp, 0);
        chk("R1 rdata", cfg_rdata, 0);

        for (int i = 0; i < NV; i++) begin
            ctl_we = TBL[i].cw; ctl_init = TBL[i].ci; ctl_sleep = TBL[i].cs; ctl_wake = TBL[i].ck;
            bus_idle = TBL[i].idle; bus_activity = TBL[i].act;
            cfg_we = TBL[i].fw; cfg_waddr = TBL[i].addr; cfg_wdata = TBL[i].data;
            tick();
            chk($sformatf("R3 init_ack row %0d", i), init_ack, TBL[i].e_iack);
            chk($sformatf("R7 sleep_ack row %0d", i), sleep_ack, TBL[i].e_sack);
            chk($sformatf("R2 sleep_req row %0d", i), sleep_req, TBL[i].e_sreq);
            chk($sformatf("R6 wr_err row %0d", i), cfg_wr_err, TBL[i].e_err);
            chk($sformatf("R5 init_active row %0d", i), init_active, TBL[i].e_iack & init_req);
        end
        quiet();

        // R6 rejected write left timing intact; R9 field layout
        cfg_raddr = 5'd0; #1;
        chk("R6 timing kept", cfg_rdata, 8'hC5);
        chk("R9 sjw_tq", sjw_tq, 4);
        chk("R9 brp", brp, 6'h05);
        cfg_raddr = 5'd3; #1;
        chk("R10 filter read", cfg_rdata, 8'h5A);

        do_reset();
        chk("R1 err after reset", cfg_wr_err, 0);
        cfg_raddr = 5'd0; #1;
        chk("R1 timing after reset", cfg_rdata, 0);

        enter_init();
        chk("R5 init_active", init_active, 1);
        chk("R5 sleep_active", sleep_active, 0);

        // R6 out-of-range address
        cfg_write(5'd20, 8'h33);
        chk("R6 range err", cfg_wr_err, 1);
        cfg_raddr = 5'd20; #1;
        chk("R10 out of range read", cfg_rdata, 0);

        // R9 every jump width code
        for (int c = 0; c < 4; c++) begin
            cfg_write(5'd0, {c[1:0], 6'h2A});
            chk($sformatf("R9 sjw code %0d", c), sjw_tq, c + 1);
            chk("R9 brp", brp, 6'h2A);
        end

        // R10 last filter register
        cfg_write(5'(NF), 8'h77);
        cfg_raddr = 5'(NF); #1;
        chk("R10 last filter", cfg_rdata, 8'h77);

        finish_run();
    end

endmodule